// File: doc/BRIEF.md
# Rise/Fall Compare Timer with Edge Capture

This block is an up-counting timer that can work in one of two modes. In waveform mode, the counter is compared against two programmable values. One value drives the output high and the other drives it low. Reaching the low value also ends the cycle. The timer can emit one pulse and halt, or it can repeat the cycle forever.

In capture mode, the same two registers record timestamps instead. After the timer is armed, the counter value is stored on the first rising edge of an external input, and again on the falling edge that follows. This measures the width of a high pulse.

Software loads the two values through a small write port and reads them back through a read port. A one-cycle `start` pulse launches either mode. The `tick` input gates counting, so a slower count rate can be derived outside the block.

Top module: `rf_timer`

## Requirements
- R1: After reset, `pwm_out` and `done` are 0 and both registers read back as 0.
- R2: In waveform mode, a start pulse clears the count to 0. On each tick, if the count equals the high-compare value (and not the low-compare value), `pwm_out` is 1 from the next cycle on.
- R3: In waveform mode, a tick on which the count equals the low-compare value drives `pwm_out` to 0 and returns the count to 0. A repeating cycle therefore lasts low-compare+1 ticks, and the output is high for low-compare minus high-compare ticks.
- R4: When the high-compare value is greater than or equal to the low-compare value, `pwm_out` stays 0 for the whole cycle.
- R5: With `one_shot`=1 at start, the timer produces exactly one pulse. It sets `done` on the tick that reaches the low-compare value and then stops counting. Only a new start pulse produces another pulse.
- R6: Register writes made while waveform mode is running are used only from the next cycle boundary. A cycle already in progress finishes with the old values.
- R7: While `out_en` is 0, `pwm_out` is held at 0 and counting continues. Raising `out_en` again shows the running waveform at once.
- R8: The counter advances only on cycles with `tick`=1. Without ticks, the output and the count hold their state.
- R9: In capture mode, the first rising edge of `cap_in` after start stores the count into the high-compare register. The input passes through a two-flop synchronizer. With `tick` held at 1 and start sampled at clock edge 0, an input change first sampled at edge k stores (k+1) modulo 2^CW.
- R10: In capture mode, the first falling edge after the stored rising edge stores the count into the low-compare register. It also sets `done`, which stays 1 until the next start; later edges change neither register.
- R11: In capture mode, `pwm_out` stays 0.
- R12: `wr_sel`/`rd_sel` select register 0 (high-compare) or 1 (low-compare). A value written with `wr_en` reads back unchanged on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| start | input | 1 | Start/arm pulse |
| cap_mode | input | 1 | 0 waveform, 1 capture (latched at start) |
| one_shot | input | 1 | 1 single pulse, 0 repeating (latched at start) |
| out_en | input | 1 | Output enable; 0 holds `pwm_out` low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write select: 0 high-compare, 1 low-compare |
| wr_data | input | CW | Write data |
| rd_sel | input | 1 | Read select: 0 high-compare, 1 low-compare |
| rd_data | output | CW | Read data of selected register |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Waveform output |
| done | output | 1 | Single pulse finished or capture complete |

## Verification
The bench builds the timer with CW=8 rather than the default 17. A capture can then run past a counter wrap within a few hundred cycles, and the modulo behaviour of R9 is checked directly. Small compare values keep whole repeating cycles, deferred updates and single pulses short enough to be scored cycle by cycle against a reference model.

// File: rtl/rf_timer.sv
module rf_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          cap_mode,
  input  logic          one_shot,
  input  logic          out_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  input  logic          cap_in,
  output logic          pwm_out,
  output logic          done
);

  logic [CW-1:0] rise_q, fall_q;
  logic [CW-1:0] rise_a, fall_a;
  logic [CW-1:0] cnt;
  logic          run, mode_q, shot_q, lvl, done_q, got_rise;
  logic [2:0]    sync;
  logic          rise_ev, fall_ev, at_fall, at_rise;

  assign rise_ev = sync[1] & ~sync[2];
  assign fall_ev = ~sync[1] & sync[2];
  assign at_fall = (cnt == fall_a);
  assign at_rise = (cnt == rise_a);

  assign rd_data = rd_sel ? fall_q : rise_q;
  assign pwm_out = out_en & lvl;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q   <= '0;
      fall_q   <= '0;
      rise_a   <= '0;
      fall_a   <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      mode_q   <= 1'b0;
      shot_q   <= 1'b0;
      lvl      <= 1'b0;
      done_q   <= 1'b0;
      got_rise <= 1'b0;
      sync     <= '0;
    end else begin
      sync <= {sync[1:0], cap_in};
      if (wr_en) begin
        if (wr_sel) fall_q <= wr_data;
        else        rise_q <= wr_data;
      end
      if (start) begin
        cnt      <= '0;
        run      <= 1'b1;
        lvl      <= 1'b0;
        done_q   <= 1'b0;
        got_rise <= 1'b0;
        mode_q   <= cap_mode;
        shot_q   <= one_shot;
        rise_a   <= rise_q;
        fall_a   <= fall_q;
      end else if (run && !mode_q) begin
        if (tick) begin
          if (at_fall) begin
            lvl <= 1'b0;
            cnt <= '0;
            if (shot_q) begin
              run    <= 1'b0;
              done_q <= 1'b1;
            end else begin
              rise_a <= rise_q;
              fall_a <= fall_q;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (at_rise) lvl <= 1'b1;
          end
        end
      end else if (run && mode_q) begin
        if (tick) cnt <= cnt + 1'b1;
        if (!got_rise && rise_ev) begin
          rise_q   <= cnt;
          got_rise <= 1'b1;
        end else if (got_rise && fall_ev) begin
          fall_q <= cnt;
          run    <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rf_timer_chk.sv
module rf_timer_chk #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          start,
  input logic          pwm_out,
  input logic          done,
  input logic          run,
  input logic          mode_q,
  input logic          shot_q,
  input logic          lvl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rise_a,
  input logic [CW-1:0] fall_a
);

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_q && tick && !start && cnt == rise_a && cnt != fall_a) |=> lvl);

  a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_q && tick && !start && cnt == fall_a) |=> (!lvl && cnt == '0));

  a_r5_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_q && shot_q && tick && !start && cnt == fall_a) |=> (!run && done));

  a_r6_no_midcycle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode_q && !start && !(tick && cnt == fall_a)) |=> ($stable(rise_a) && $stable(fall_a)));

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> ($stable(cnt) && $stable(lvl)));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r11_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q) |-> !pwm_out);

endmodule

bind rf_timer rf_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .pwm_out(pwm_out),
  .done(done), .run(run), .mode_q(mode_q), .shot_q(shot_q), .lvl(lvl),
  .cnt(cnt), .rise_a(rise_a), .fall_a(fall_a)
);

// File: tb/sim_rf_timer.sv
`timescale 1ns/1ps
module sim_rf_timer;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, tick = 1, start = 0, cap_mode = 0, one_shot = 0;
  logic out_en = 1, wr_en = 0, wr_sel = 0, rd_sel = 0, cap_in = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic pwm_out, done;

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_tag = "R2";

  typedef struct { logic p; logic d; string tag; } exp_t;
  exp_t sb[$];

  // reference state for waveform mode
  logic [W-1:0] mr = '0, mf = '0, ar = '0, af = '0, mcnt = '0;
  logic mrun = 0, mlvl = 0, mdone = 0, mshot = 0;

  rf_timer #(.CW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cap_mode(cap_mode),
    .one_shot(one_shot), .out_en(out_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cap_in(cap_in),
    .pwm_out(pwm_out), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expectations after each clock edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " pwm"}, {31'd0, pwm_out}, {31'd0, e.p});
      check({e.tag, " done"}, {31'd0, done}, {31'd0, e.d});
    end
  end

  // driver: inputs are set at negedge; advance the model and push the result
  task automatic step();
    exp_t e;
    if (start) begin
      mcnt = '0; mrun = 1; mlvl = 0; mdone = 0; ar = mr; af = mf; mshot = one_shot;
    end else if (mrun && tick) begin
      if (mcnt == af) begin
        mlvl = 0; mcnt = '0;
        if (mshot) begin mrun = 0; mdone = 1; end
        else begin ar = mr; af = mf; end
      end else begin
        if (mcnt == ar) mlvl = 1;
        mcnt = mcnt + 1'b1;
      end
    end
    if (wr_en) begin
      if (wr_sel) mf = wr_data; else mr = wr_data;
    end
    e.p = out_en & mlvl; e.d = mdone; e.tag = cur_tag;
    sb.push_back(e);
    @(negedge clk);
    start = 0; wr_en = 0;
  endtask

  task automatic run_steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic sel, logic [W-1:0] v);
    wr_en = 1; wr_sel = sel; wr_data = v;
    step();
  endtask

  task automatic go(logic shot);
    one_shot = shot; cap_mode = 0; start = 1;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_sel = 0; #1;
    check("R1 pwm", {31'd0, pwm_out}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 rise reg", {24'd0, rd_data}, 0);
    rd_sel = 1; #1;
    check("R1 fall reg", {24'd0, rd_data}, 0);
    @(negedge clk);

    // R12 register port
    cur_tag = "R12";
    wr(0, 8'd2); wr(1, 8'd5);
    rd_sel = 0; #1; check("R12 rise readback", {24'd0, rd_data}, 2);
    rd_sel = 1; #1; check("R12 fall readback", {24'd0, rd_data}, 5);

    // R2/R3 repeating waveform
    cur_tag = "R3"; go(0); run_steps(20);
    cur_tag = "R2"; wr(0, 8'd0); wr(1, 8'd3); go(0); run_steps(12);

    // R4 rise >= fall keeps output low
    cur_tag = "R4"; wr(0, 8'd5); wr(1, 8'd3); go(0); run_steps(12);
    wr(0, 8'd4); wr(1, 8'd4); go(0); run_steps(12);

    // R5 single pulse
    cur_tag = "R5"; wr(0, 8'd1); wr(1, 8'd4); go(1); run_steps(15);
    go(1); run_steps(10);

    // R6 deferred update
    cur_tag = "R6"; wr(0, 8'd1); wr(1, 8'd3); go(0); run_steps(2);
    wr(0, 8'd4); wr(1, 8'd7); run_steps(22);

    // R7 output enable
    cur_tag = "R7"; wr(0, 8'd1); wr(1, 8'd4); go(0); run_steps(3);
    out_en = 0; run_steps(8);
    out_en = 1; run_steps(8);

    // R8 tick gating
    cur_tag = "R8"; go(0);
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3 == 0);
      step();
    end
    tick = 1;
    @(negedge clk); @(negedge clk);

    // R9/R10/R11 capture
    cap_mode = 1; start = 1; @(negedge clk); start = 0;
    for (int i = 1; i <= 20; i++) begin
      cap_in = (i >= 5 && i < 12);
      @(negedge clk);
      if (i == 8) check("R11 pwm in capture", {31'd0, pwm_out}, 0);
    end
    check("R10 done after capture", {31'd0, done}, 1);
    rd_sel = 0; #1; check("R9 rise stamp", {24'd0, rd_data}, 6);
    rd_sel = 1; #1; check("R10 fall stamp", {24'd0, rd_data}, 13);
    for (int i = 0; i < 8; i++) begin
      cap_in = (i >= 2 && i < 5);
      @(negedge clk);
    end
    rd_sel = 0; #1; check("R10 rise unchanged", {24'd0, rd_data}, 6);
    rd_sel = 1; #1; check("R10 fall unchanged", {24'd0, rd_data}, 13);
    check("R10 done held", {31'd0, done}, 1);

    // R9 wrap: rise first sampled at edge 300, fall at edge 310
    start = 1; @(negedge clk); start = 0;
    check("R10 done cleared by start", {31'd0, done}, 0);
    for (int i = 1; i <= 320; i++) begin
      cap_in = (i >= 300 && i < 310);
      @(negedge clk);
    end
    rd_sel = 0; #1; check("R9 wrapped rise", {24'd0, rd_data}, 301 % 256);
    rd_sel = 1; #1; check("R10 wrapped fall", {24'd0, rd_data}, 311 % 256);
    check("R11 pwm idle", {31'd0, pwm_out}, 0);

    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule